// File: doc/BRIEF.md
# Per-cell pedestal subtraction pipeline

This block is a calibration stage for digitized waveform samples from a switched-capacitor sampling array. Each incoming sample carries the index of the physical storage cell it was read from. The stage looks up that cell's pedestal, subtracts it, and keeps the signed result without clamping. It also looks up a per-cell time offset and adds it to the sample's nominal time within its waveform. Samples enter and leave at one per clock.

In parallel, a background unit scans each corrected waveform. It reports the index of the first sample that lies strictly above a programmable level, or all-ones when no sample gets there. A waveform is a fixed run of `WAVE_LEN` samples on consecutive cycles, and the first of them is flagged by a marker. The result comes out a fixed, short number of clocks after the waveform's last sample, well inside a 256-clock budget. Both tables sit in on-chip synchronous RAM. They are loaded through a write port that works only while the stream is idle, and a write attempted while samples are in flight is refused and flagged.

Top module: `ped_sub_pipe`

## Requirements
- R1: While reset is low and right after it is released, `cor_valid`, `tof_valid` and `tbl_reject` are 0.
- R2: `cor_value` is the signed difference `smp_code - pedestal[smp_cell]`, `SAMPLE_W+1` bits in two's complement. Negative results are kept as they are and never clamped. It appears two clocks after the sample is taken.
- R3: The stage takes one sample per clock. `cor_valid` repeats `smp_valid` two clocks later, and it drops two clocks after the last input sample.
- R4: `cor_time` equals `idx * 2^FRAC_W` plus the cell's time offset. The offset is stored as a `SAMPLE_W`-bit two's complement value. `cor_time` is signed, `SAMPLE_W+2` bits wide.
- R5: The in-waveform index `cor_idx` is 0 for a sample with `smp_first` = 1 and rises by one with each further valid sample. `cor_first` marks the output of index 0.
- R6: A write with `tbl_we` = 1 while no sample is in flight is accepted. `tbl_sel` = 0 selects the pedestal table and `tbl_sel` = 1 the offset table. The new value is used by every later sample from that cell, and `tbl_reject` stays 0.
- R7: A write is ignored when it is attempted while `smp_valid` is high or a sample is still in the pipeline. `tbl_reject` then pulses high on the next clock.
- R8: `tof_valid` pulses one clock after the output of the sample with index `WAVE_LEN-1`. `tof_idx` then gives the first index whose `cor_value` is strictly greater than `hit_level`, compared as signed values. A value equal to the level does not count.
- R9: When no sample of the waveform exceeds `hit_level`, `tof_idx` is all-ones (`2^(IDX_W+1)-1`). This code can never be taken for a real index.
- R10: The timing result arrives `WAVE_LEN+2` clocks after the waveform's first sample is taken, which is within 256 clocks for the default `WAVE_LEN` of 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Input sample valid |
| smp_first | input | 1 | Sample is the first of a waveform |
| smp_cell | input | CELL_AW | Storage cell index of the sample |
| smp_code | input | SAMPLE_W | Raw ADC code (unsigned) |
| tbl_we | input | 1 | Table write request |
| tbl_sel | input | 1 | 0 = pedestal table, 1 = offset table |
| tbl_addr | input | CELL_AW | Cell index to write |
| tbl_wdata | input | SAMPLE_W | Value to write |
| hit_level | input | SAMPLE_W+1 | Signed crossing level for the timing result |
| cor_valid | output | 1 | Corrected sample valid |
| cor_first | output | 1 | Corrected sample is index 0 |
| cor_idx | output | IDX_W | Index of the sample within its waveform |
| cor_value | output | SAMPLE_W+1 | Pedestal-subtracted sample, signed |
| cor_time | output | SAMPLE_W+2 | Corrected sample time, signed |
| tof_valid | output | 1 | Timing result valid (one-clock pulse) |
| tof_idx | output | IDX_W+1 | First crossing index, or all-ones |
| tbl_reject | output | 1 | A table write was refused last clock |

## Verification
Several properties are checked on every clock. The output valid must follow the input valid two clocks later, and a write attempted during a live sample must raise the reject flag. The timing result may appear only right after a waveform's last sample, and its index must be in range or the all-ones code. Other behaviour depends on the contents of the tables, so only the directed scenarios can show it. These cover the arithmetic of subtraction and time placement against the bench's own model, negative results that are not clamped, and the strict comparison at a level equal to the sample. They also cover the all-ones miss code, and whether a refused write truly left the pedestal untouched while an idle write took effect.

// File: rtl/ped_pkg.sv
package ped_pkg;
  typedef enum logic {
    TBL_PED = 1'b0,
    TBL_OFS = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/ped_ram.sv
module ped_ram #(
  parameter int AW = 11,
  parameter int DW = 12,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ped_correct.sv
module ped_correct #(
  parameter int SAMPLE_W = 12,
  parameter int IDX_W    = 6,
  parameter int FRAC_W   = 4,
  localparam int DIFF_W  = SAMPLE_W + 1,
  localparam int TIME_W  = SAMPLE_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_first,
  input  logic [IDX_W-1:0]         in_idx,
  input  logic [SAMPLE_W-1:0]      in_code,
  input  logic [SAMPLE_W-1:0]      ped,
  input  logic [SAMPLE_W-1:0]      ofs,
  output logic                     out_valid,
  output logic                     out_first,
  output logic [IDX_W-1:0]         out_idx,
  output logic signed [DIFF_W-1:0] out_value,
  output logic signed [TIME_W-1:0] out_time
);
  function automatic logic signed [DIFF_W-1:0] strip_ped(
    input logic [SAMPLE_W-1:0] code, input logic [SAMPLE_W-1:0] base);
    return $signed({1'b0, code}) - $signed({1'b0, base});
  endfunction

  function automatic logic signed [TIME_W-1:0] place_time(
    input logic [IDX_W-1:0] idx, input logic [SAMPLE_W-1:0] shift);
    logic signed [TIME_W-1:0] nominal, delta;
    nominal = $signed({{(TIME_W-IDX_W-FRAC_W){1'b0}}, idx, {FRAC_W{1'b0}}});
    delta   = $signed({{2{shift[SAMPLE_W-1]}}, shift});
    return nominal + delta;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_first <= in_valid & in_first;
    end
    if (in_valid) begin
      out_idx   <= in_idx;
      out_value <= strip_ped(in_code, ped);
      out_time  <= place_time(in_idx, ofs);
    end
  end
endmodule

// File: rtl/ped_tof.sv
module ped_tof #(
  parameter int SAMPLE_W = 12,
  parameter int WAVE_LEN = 64,
  localparam int IDX_W   = $clog2(WAVE_LEN),
  localparam int HIT_W   = IDX_W + 1,
  localparam int DIFF_W  = SAMPLE_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v,
  input  logic                     first,
  input  logic [IDX_W-1:0]         idx,
  input  logic signed [DIFF_W-1:0] value,
  input  logic signed [DIFF_W-1:0] level,
  output logic                     res_valid,
  output logic [HIT_W-1:0]         res_idx
);
  localparam logic [HIT_W-1:0] MISS = {HIT_W{1'b1}};
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WAVE_LEN - 1);

  logic             found_q;
  logic [HIT_W-1:0] first_q;
  logic             prev_found, over_now, last_now;
  logic [HIT_W-1:0] nxt_idx;

  always_comb begin
    prev_found = first ? 1'b0 : found_q;
    over_now   = value > level;
    last_now   = v && (idx == LAST);
    if (prev_found)    nxt_idx = first ? MISS : first_q;
    else if (over_now) nxt_idx = {1'b0, idx};
    else               nxt_idx = MISS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      found_q   <= 1'b0;
      first_q   <= MISS;
      res_valid <= 1'b0;
      res_idx   <= MISS;
    end else begin
      res_valid <= last_now;
      if (v) begin
        found_q <= prev_found | over_now;
        first_q <= nxt_idx;
      end
      if (last_now) res_idx <= nxt_idx;
    end
  end

  AST_TOF_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_now |=> res_valid); // R8
  AST_TOF_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(v) && ($past(idx) == LAST)); // R8
  AST_TOF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_idx == MISS) || (res_idx < HIT_W'(WAVE_LEN))); // R9
endmodule

// File: rtl/ped_sub_pipe.sv
module ped_sub_pipe
  import ped_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int CELL_AW  = 11,
  parameter int WAVE_LEN = 64,
  parameter int FRAC_W   = 4,
  localparam int IDX_W   = $clog2(WAVE_LEN),
  localparam int HIT_W   = IDX_W + 1,
  localparam int DIFF_W  = SAMPLE_W + 1,
  localparam int TIME_W  = SAMPLE_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic                smp_first,
  input  logic [CELL_AW-1:0]  smp_cell,
  input  logic [SAMPLE_W-1:0] smp_code,
  input  logic                tbl_we,
  input  logic                tbl_sel,
  input  logic [CELL_AW-1:0]  tbl_addr,
  input  logic [SAMPLE_W-1:0] tbl_wdata,
  input  logic [DIFF_W-1:0]   hit_level,
  output logic                cor_valid,
  output logic                cor_first,
  output logic [IDX_W-1:0]    cor_idx,
  output logic [DIFF_W-1:0]   cor_value,
  output logic [TIME_W-1:0]   cor_time,
  output logic                tof_valid,
  output logic [HIT_W-1:0]    tof_idx,
  output logic                tbl_reject
);
  // Stage 1 state: table read in flight
  logic                s1_valid, s1_first;
  logic [IDX_W-1:0]    s1_idx;
  logic [SAMPLE_W-1:0] s1_code;
  logic [IDX_W-1:0]    idx_cnt;
  logic [IDX_W-1:0]    cur_idx;
  logic [SAMPLE_W-1:0] ped_rd, ofs_rd;

  // Named internal events
  logic stream_busy, wr_go, ped_we, ofs_we;

  assign stream_busy = smp_valid | s1_valid | cor_valid;
  assign wr_go       = tbl_we & ~stream_busy;
  assign ped_we      = wr_go & (tbl_sel_e'(tbl_sel) == TBL_PED);
  assign ofs_we      = wr_go & (tbl_sel_e'(tbl_sel) == TBL_OFS);
  assign cur_idx     = smp_first ? '0 : idx_cnt + 1'b1;

  ped_ram #(.AW(CELL_AW), .DW(SAMPLE_W)) u_ped_tbl (
    .clk(clk), .we(ped_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .re(smp_valid), .raddr(smp_cell), .rdata(ped_rd));

  ped_ram #(.AW(CELL_AW), .DW(SAMPLE_W)) u_ofs_tbl (
    .clk(clk), .we(ofs_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .re(smp_valid), .raddr(smp_cell), .rdata(ofs_rd));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_first   <= 1'b0;
      idx_cnt    <= '1;
      tbl_reject <= 1'b0;
    end else begin
      s1_valid   <= smp_valid;
      s1_first   <= smp_valid & smp_first;
      tbl_reject <= tbl_we & stream_busy;
      if (smp_valid) idx_cnt <= cur_idx;
    end
    if (smp_valid) begin
      s1_idx  <= cur_idx;
      s1_code <= smp_code;
    end
  end

  logic signed [DIFF_W-1:0] cor_value_s;
  logic signed [TIME_W-1:0] cor_time_s;

  ped_correct #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_correct (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s1_valid), .in_first(s1_first), .in_idx(s1_idx),
    .in_code(s1_code), .ped(ped_rd), .ofs(ofs_rd),
    .out_valid(cor_valid), .out_first(cor_first), .out_idx(cor_idx),
    .out_value(cor_value_s), .out_time(cor_time_s));

  assign cor_value = cor_value_s;
  assign cor_time  = cor_time_s;

  ped_tof #(.SAMPLE_W(SAMPLE_W), .WAVE_LEN(WAVE_LEN)) u_tof (
    .clk(clk), .rst_n(rst_n),
    .v(cor_valid), .first(cor_first), .idx(cor_idx),
    .value(cor_value_s), .level($signed(hit_level)),
    .res_valid(tof_valid), .res_idx(tof_idx));

  AST_ONE_PER_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cor_valid == $past(smp_valid, 2)); // R3
  AST_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && smp_valid) |=> tbl_reject); // R7
  AST_NO_WRITE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (ped_we || ofs_we) |-> !smp_valid && !cor_valid); // R7
  AST_FIRST_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cor_first |-> cor_valid && (cor_idx == '0)); // R5
endmodule

// File: tb/ped_sub_pipe_test.sv
module ped_sub_pipe_test;
  localparam int SAMPLE_W = 12;
  localparam int CELL_AW  = 11;
  localparam int WAVE_LEN = 64;
  localparam int FRAC_W   = 4;
  localparam int IDX_W    = $clog2(WAVE_LEN);
  localparam int HIT_W    = IDX_W + 1;
  localparam int MISS     = (1 << HIT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0, smp_first = 1'b0;
  logic [CELL_AW-1:0] smp_cell = '0;
  logic [SAMPLE_W-1:0] smp_code = '0;
  logic tbl_we = 1'b0, tbl_sel = 1'b0;
  logic [CELL_AW-1:0] tbl_addr = '0;
  logic [SAMPLE_W-1:0] tbl_wdata = '0;
  logic [SAMPLE_W:0] hit_level = '0;
  logic cor_valid, cor_first, tof_valid, tbl_reject;
  logic [IDX_W-1:0] cor_idx;
  logic [SAMPLE_W:0] cor_value;
  logic [SAMPLE_W+1:0] cor_time;
  logic [HIT_W-1:0] tof_idx;

  ped_sub_pipe #(.SAMPLE_W(SAMPLE_W), .CELL_AW(CELL_AW), .WAVE_LEN(WAVE_LEN),
                 .FRAC_W(FRAC_W)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_first(smp_first),
    .smp_cell(smp_cell), .smp_code(smp_code), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .hit_level(hit_level),
    .cor_valid(cor_valid), .cor_first(cor_first), .cor_idx(cor_idx),
    .cor_value(cor_value), .cor_time(cor_time), .tof_valid(tof_valid),
    .tof_idx(tof_idx), .tbl_reject(tbl_reject));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int ped_m [1 << CELL_AW];
  int ofs_m [1 << CELL_AW];
  int wave  [WAVE_LEN];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "cor_valid in reset", int'(cor_valid), 0);
    chk("R1", "tof_valid in reset", int'(tof_valid), 0);
    chk("R1", "tbl_reject in reset", int'(tbl_reject), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cor_valid after reset", int'(cor_valid), 0);
    chk("R1", "tbl_reject after reset", int'(tbl_reject), 0);
  endtask

  task automatic wr_tbl(input bit sel, input int addr, input int val, input bit check);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_addr = CELL_AW'(addr); tbl_wdata = SAMPLE_W'(val);
    if (sel) ofs_m[addr] = val; else ped_m[addr] = val;
    @(negedge clk);
    tbl_we = 1'b0;
    if (check) chk("R6", "tbl_reject on idle write", int'(tbl_reject), 0);
  endtask

  task automatic load_tables();
    for (int c = 0; c < 512; c++) begin
      wr_tbl(1'b0, c, 1800 + (c * 37) % 400, c == 0);
      wr_tbl(1'b1, c, (c * 29) % 256 - 128, 1'b0);
    end
  endtask

  // Stream one waveform from cell base; optionally try a write at sample bad_at
  task automatic run_wave(input string tag, input int base, input int level, input int bad_at);
    int exp_v [WAVE_LEN];
    int exp_first;
    exp_first = MISS;
    for (int k = 0; k < WAVE_LEN; k++) begin
      exp_v[k] = wave[k] - ped_m[base + k];
      if (exp_first == MISS && exp_v[k] > level) exp_first = k;
    end
    hit_level = (SAMPLE_W + 1)'(level);
    for (int i = 0; i <= WAVE_LEN + 2; i++) begin
      @(negedge clk);
      if (i >= 2 && i - 2 < WAVE_LEN) begin
        chk("R3", {tag, " cor_valid"}, int'(cor_valid), 1);
        chk("R2", {tag, " cor_value"}, int'($signed(cor_value)), exp_v[i-2]);
        chk("R4", {tag, " cor_time"}, int'($signed(cor_time)),
            (i - 2) * (1 << FRAC_W) + ofs_m[base + i - 2]);
        chk("R5", {tag, " cor_idx"}, int'(cor_idx), i - 2);
        chk("R5", {tag, " cor_first"}, int'(cor_first), (i == 2) ? 1 : 0);
      end
      if (i == WAVE_LEN + 1) chk("R8", {tag, " tof_valid early"}, int'(tof_valid), 0);
      if (i == WAVE_LEN + 2) begin
        chk("R3", {tag, " cor_valid drops"}, int'(cor_valid), 0);
        chk("R10", {tag, " tof_valid on time"}, int'(tof_valid), 1);
        chk(exp_first == MISS ? "R9" : "R8", {tag, " tof_idx"}, int'(tof_idx), exp_first);
      end
      if (bad_at >= 0 && i == bad_at + 1)
        chk("R7", {tag, " tbl_reject"}, int'(tbl_reject), 1);
      if (i < WAVE_LEN) begin
        smp_valid = 1'b1; smp_first = (i == 0);
        smp_cell = CELL_AW'(base + i); smp_code = SAMPLE_W'(wave[i]);
      end else begin
        smp_valid = 1'b0; smp_first = 1'b0;
      end
      if (bad_at >= 0 && i == bad_at) begin
        tbl_we = 1'b1; tbl_sel = 1'b0; tbl_addr = CELL_AW'(base + 3); tbl_wdata = '0;
      end else tbl_we = 1'b0;
    end
    @(negedge clk);
    chk("R8", {tag, " tof_valid pulse"}, int'(tof_valid), 0);
  endtask

  task automatic scen_crossing();
    for (int k = 0; k < WAVE_LEN; k++) wave[k] = ped_m[128 + k] + 5 + (k % 3);
    wave[20] = ped_m[148] + 300;
    run_wave("crossing", 128, 100, -1);
  endtask

  task automatic scen_negative();
    for (int k = 0; k < WAVE_LEN; k++) wave[k] = ped_m[200 + k] - 50 - k;
    run_wave("negative", 200, 0, -1);
  endtask

  task automatic scen_equal_level();
    for (int k = 0; k < WAVE_LEN; k++) wave[k] = ped_m[300 + k] + 10;
    wave[5] = ped_m[305] + 40;
    wave[9] = ped_m[309] + 41;
    run_wave("equal", 300, 40, -1);
  endtask

  task automatic scen_busy_write();
    for (int k = 0; k < WAVE_LEN; k++) wave[k] = ped_m[128 + k] + 5 + (k % 3);
    wave[20] = ped_m[148] + 300;
    run_wave("busywr", 128, 100, 10);
    run_wave("busywr_after", 128, 100, -1);
  endtask

  task automatic scen_idle_write();
    wr_tbl(1'b0, 130, 1000, 1'b1);
    wr_tbl(1'b1, 130, -1500, 1'b1);
    run_wave("idlewr", 128, 100, -1);
  endtask

  initial begin
    do_reset();
    load_tables();
    scen_crossing();
    scen_negative();
    scen_equal_level();
    scen_busy_write();
    scen_idle_write();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule